// File: doc/BRIEF.md
# UART Channel Loopback Mode Router

This block sits between one UART channel's transmitter core, its receiver core and the two serial pins. A 2-bit mode field picks one of four routings: normal operation, automatic echo of received traffic, local loopback of the transmitter into the receiver, and remote loopback that returns the line to its sender without involving the CPU. For each routing it chooses which baud strobe paces each direction and produces the enables that the CPU-facing logic uses to show or hide transmitter status, to accept or refuse transmit data, and to deliver receive data, error flags and parity/framing checks.

Echoed traffic is reclocked by a single register that captures the RxD pin on each receiver bit-sample strobe, so parity bits, stop bits and break conditions leave on TxD exactly as they arrived. A mode change is applied in the same cycle, even within a character. The one exception: when an echoing mode is left while a just-sampled stop bit is still being retransmitted and the transmitter is enabled, TxD keeps echoing until that stop time has run out, counted in receive baud ticks.

Both baud "clocks" are single-cycle enable strobes in the system clock domain.

Top module: `uart_loop_router`

## Requirements
- R1: Mode code 2'b00 (normal): TxD follows the transmitter serial output, the receiver input follows RxD, the receiver is paced by the receive baud tick and the transmitter by the transmit baud tick, and all five gating enables (tx status, tx CPU load, rx CPU data, rx error flags, rx checking) are 1.
- R2: Mode code 2'b01 (echo): TxD shows the RxD value captured at the most recent receiver bit-sample strobe, holds it between strobes, and the transmitter is paced by the receive baud tick.
- R3: In echo mode the tx status and tx CPU load enables are 0 while rx CPU data, rx error flags and rx checking enables stay 1; the receiver input still follows RxD.
- R4: Mode code 2'b10 (local loopback): the receiver input is the transmitter serial output, both directions are paced by the transmit baud tick, TxD is held at 1, and RxD has no effect on any output.
- R5: Mode code 2'b11 (remote loopback): TxD carries the reclocked RxD as in R2, the transmitter is paced by the receive baud tick, and all five gating enables are 0.
- R6: In both echoing modes a sustained low on RxD (a break) stays low on TxD across any number of sample strobes and returns high only after RxD is high at a sample strobe.
- R7: Leaving an echoing mode with no stop bit pending switches TxD to the new routing in the same cycle as the mode field changes.
- R8: If an echoing mode is left after a receiver stop-bit strobe, before stop_len receive baud ticks (a stop_len of 0 counts as 1) have elapsed, and tx_enable is 1, TxD keeps showing the echoed bit until the cycle after the last of those ticks, then follows the new routing.
- R9: The same departure with tx_enable at 0 switches TxD immediately, as in R7.
- R10: After synchronous reset the echo register holds 1, so an echoing mode drives TxD high before any sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Routing mode code |
| tx_enable | input | 1 | Transmitter enabled |
| stop_len | input | STOP_W | Stop time in receive baud ticks held after leaving echo |
| rxd_pin | input | 1 | Serial line in |
| tx_serial | input | 1 | Transmitter core serial output |
| rx_samp_stb | input | 1 | Receiver sampled a bit this cycle |
| rx_stop_stb | input | 1 | Receiver sampled a stop bit this cycle |
| rx_baud_tick | input | 1 | Receive baud strobe |
| tx_baud_tick | input | 1 | Transmit baud strobe |
| txd_pin | output | 1 | Serial line out |
| rx_serial_in | output | 1 | Receiver core serial input |
| rx_clk_en | output | 1 | Baud strobe pacing the receiver |
| tx_clk_en | output | 1 | Baud strobe pacing the transmitter |
| tx_stat_en | output | 1 | Transmitter ready/empty status may show |
| tx_cpu_en | output | 1 | CPU may load the transmitter |
| rx_cpu_en | output | 1 | Received data goes to the CPU |
| rx_err_en | output | 1 | Receiver error flags active |
| rx_chk_en | output | 1 | Parity and framing checks active |

## Verification
The mode field changing and a stop-bit-driven hold can meet in one cycle: the departure from echo is evaluated against the stop counter in the very cycle the mode field moves, so TxD must already show the held echo bit in that cycle rather than one later. The bench provokes this by strobing a stop bit, moving the mode field to normal with tx_enable high and a transmitter output of 0, and then judging TxD after each receive baud tick against the stop_len count. The same departure with tx_enable low, and a mid-character departure with no stop pending, must instead switch TxD at once.

// File: rtl/uart_lbk_pkg.sv
// Package: shared mode type and the helper that tells echoing modes apart.
package uart_lbk_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ECHO   = 2'b01,
        MODE_LOCAL  = 2'b10,
        MODE_REMOTE = 2'b11
    } lbk_mode_e;

    // True for the two modes that send received data back out on TxD.
    function automatic logic is_relay(input lbk_mode_e m);
        return (m == MODE_ECHO) || (m == MODE_REMOTE);
    endfunction

endpackage

// File: rtl/lbk_reclock.sv
// Module: lbk_reclock
// Captures the RxD pin on every receiver bit-sample strobe so that echoed
// data leaves from a register. Assumes the strobe is one system-clock wide
// and that RxD is already synchronised into the clk domain.
module lbk_reclock (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_stb,
    input  logic rxd,
    output logic echo_bit
);

    // Echo register: idle-high after reset, loads RxD on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            echo_bit <= 1'b1;
        else if (samp_stb)
            echo_bit <= rxd;
    end

    // R10: the register leaves reset at line idle.
    assert_reset_idle_R10: assert property (@(posedge clk)
        !$past(rst_n) && rst_n |-> echo_bit);

endmodule

// File: rtl/lbk_hold_ctl.sv
// Module: lbk_hold_ctl
// Decides whether the transmit side is in an echoing routing. Follows the
// mode field at once, except that leaving an echoing mode while a sampled
// stop bit is still being retransmitted (and the transmitter is enabled)
// keeps the echo routing until stop_len receive baud ticks have passed.
// Assumes stop_len is stable while a stop bit is pending.
module lbk_hold_ctl
    import uart_lbk_pkg::*;
#(
    parameter int STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lbk_mode_e         mode_sel,
    input  logic              tx_enable,
    input  logic              stop_stb,
    input  logic              baud_tick,
    input  logic [STOP_W-1:0] stop_len,
    output logic              relay_tx
);

    localparam logic [STOP_W-1:0] ONE = STOP_W'(1);

    lbk_mode_e         mode_q;
    logic [STOP_W-1:0] cnt_q, cnt_nxt;
    logic              hold_q, hold_now, leave_now, load;

    // Departure from an echoing mode while stop time remains.
    always_comb begin
        leave_now = is_relay(mode_q) && !is_relay(mode_sel)
                    && (cnt_q != '0) && tx_enable;
        hold_now  = hold_q || leave_now;
        relay_tx  = is_relay(mode_sel) || hold_now;
        load      = stop_stb && relay_tx;
    end

    // Next value of the remaining stop time counter.
    always_comb begin
        if (load)
            cnt_nxt = (stop_len == '0) ? ONE : stop_len;
        else if (baud_tick && (cnt_q != '0))
            cnt_nxt = cnt_q - ONE;
        else
            cnt_nxt = cnt_q;
    end

    // State: previous mode, stop time left, and the hold flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            mode_q <= mode_sel;
            cnt_q  <= cnt_nxt;
            hold_q <= hold_now && (cnt_nxt != '0) && !is_relay(mode_sel);
        end
    end

    // R8: a hold only exists while stop time remains.
    assert_hold_has_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (cnt_q != '0));

    // R8: stop time falls by one per receive baud tick.
    assert_stop_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && baud_tick && !load |=> cnt_q == $past(cnt_q) - ONE);

    // R9: without an enabled transmitter no hold is ever entered.
    assert_no_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable && !hold_q |=> !hold_q);

endmodule

// File: rtl/lbk_route.sv
// Module: lbk_route
// Combinational steering of serial data, baud strobes and CPU-side gating.
// The transmit side follows relay_tx (which may lag the mode field during
// a stop-bit hold); the receive side follows the mode field directly.
module lbk_route
    import uart_lbk_pkg::*;
(
    input  lbk_mode_e mode_sel,
    input  logic      relay_tx,
    input  logic      echo_bit,
    input  logic      tx_serial,
    input  logic      rxd_pin,
    input  logic      rx_baud_tick,
    input  logic      tx_baud_tick,
    output logic      txd_pin,
    output logic      rx_serial_in,
    output logic      rx_clk_en,
    output logic      tx_clk_en,
    output logic      tx_stat_en,
    output logic      tx_cpu_en,
    output logic      rx_cpu_en,
    output logic      rx_err_en,
    output logic      rx_chk_en
);

    logic local_lb, remote_lb;

    // Transmit side: pin source, pacing strobe and CPU visibility.
    always_comb begin
        local_lb = (mode_sel == MODE_LOCAL);
        if (relay_tx)
            txd_pin = echo_bit;
        else if (local_lb)
            txd_pin = 1'b1;
        else
            txd_pin = tx_serial;
        tx_clk_en  = relay_tx ? rx_baud_tick : tx_baud_tick;
        tx_stat_en = !relay_tx;
        tx_cpu_en  = !relay_tx;
    end

    // Receive side: input source, pacing strobe and CPU delivery.
    always_comb begin
        remote_lb    = (mode_sel == MODE_REMOTE);
        rx_serial_in = local_lb ? tx_serial : rxd_pin;
        rx_clk_en    = local_lb ? tx_baud_tick : rx_baud_tick;
        rx_cpu_en    = !remote_lb;
        rx_err_en    = !remote_lb;
        rx_chk_en    = !remote_lb;
    end

endmodule

// File: rtl/uart_loop_router.sv
// Module: uart_loop_router
// Top of the loopback mode router for one UART channel. Assumes all
// inputs are synchronous to clk and every strobe is one cycle wide.
module uart_loop_router
    import uart_lbk_pkg::*;
#(
    parameter int STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              tx_enable,
    input  logic [STOP_W-1:0] stop_len,
    input  logic              rxd_pin,
    input  logic              tx_serial,
    input  logic              rx_samp_stb,
    input  logic              rx_stop_stb,
    input  logic              rx_baud_tick,
    input  logic              tx_baud_tick,
    output logic              txd_pin,
    output logic              rx_serial_in,
    output logic              rx_clk_en,
    output logic              tx_clk_en,
    output logic              tx_stat_en,
    output logic              tx_cpu_en,
    output logic              rx_cpu_en,
    output logic              rx_err_en,
    output logic              rx_chk_en
);

    lbk_mode_e mode_e;
    logic      echo_bit;
    logic      relay_tx;

    assign mode_e = lbk_mode_e'(mode_sel);

    lbk_reclock u_reclock (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_stb (rx_samp_stb),
        .rxd      (rxd_pin),
        .echo_bit (echo_bit)
    );

    lbk_hold_ctl #(.STOP_W(STOP_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_e),
        .tx_enable (tx_enable),
        .stop_stb  (rx_stop_stb),
        .baud_tick (rx_baud_tick),
        .stop_len  (stop_len),
        .relay_tx  (relay_tx)
    );

    lbk_route u_route (
        .mode_sel     (mode_e),
        .relay_tx     (relay_tx),
        .echo_bit     (echo_bit),
        .tx_serial    (tx_serial),
        .rxd_pin      (rxd_pin),
        .rx_baud_tick (rx_baud_tick),
        .tx_baud_tick (tx_baud_tick),
        .txd_pin      (txd_pin),
        .rx_serial_in (rx_serial_in),
        .rx_clk_en    (rx_clk_en),
        .tx_clk_en    (tx_clk_en),
        .tx_stat_en   (tx_stat_en),
        .tx_cpu_en    (tx_cpu_en),
        .rx_cpu_en    (rx_cpu_en),
        .rx_err_en    (rx_err_en),
        .rx_chk_en    (rx_chk_en)
    );

    // R2: in an echoing mode TxD shows RxD from the last sample strobe.
    assert_echo_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && is_relay(mode_e) && $past(is_relay(mode_e))
        && $past(rx_samp_stb) |-> txd_pin == $past(rxd_pin));

    // R2: between strobes an echoing TxD does not move.
    assert_echo_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && is_relay(mode_e) && $past(is_relay(mode_e))
        && !$past(rx_samp_stb) |-> $stable(txd_pin));

    // R4: local loopback keeps the line idle and feeds the receiver locally.
    assert_local_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_LOCAL) && !relay_tx |-> txd_pin && (rx_serial_in == tx_serial));

    // R5: remote loopback delivers nothing and flags nothing to the CPU.
    assert_remote_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_REMOTE) |-> !rx_cpu_en && !rx_err_en && !tx_stat_en);

endmodule

// File: tb/tb_uart_loop_router.sv
module tb_uart_loop_router;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       tx_enable;
    logic [1:0] stop_len;
    logic       rxd_pin, tx_serial, rx_samp_stb, rx_stop_stb;
    logic       rx_baud_tick, tx_baud_tick;
    logic       txd_pin, rx_serial_in, rx_clk_en, tx_clk_en;
    logic       tx_stat_en, tx_cpu_en, rx_cpu_en, rx_err_en, rx_chk_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_loop_router #(.STOP_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_enable(tx_enable),
        .stop_len(stop_len), .rxd_pin(rxd_pin), .tx_serial(tx_serial),
        .rx_samp_stb(rx_samp_stb), .rx_stop_stb(rx_stop_stb),
        .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick),
        .txd_pin(txd_pin), .rx_serial_in(rx_serial_in), .rx_clk_en(rx_clk_en),
        .tx_clk_en(tx_clk_en), .tx_stat_en(tx_stat_en), .tx_cpu_en(tx_cpu_en),
        .rx_cpu_en(rx_cpu_en), .rx_err_en(rx_err_en), .rx_chk_en(rx_chk_en)
    );

    // [14:13] mode [12] rxd [11] tx_serial [10] rx tick [9] tx tick |
    // expected [8] txd [7] rx_in [6] rx_clk [5] tx_clk [4] tx_stat [3] tx_cpu
    // [2] rx_cpu [1] rx_err [0] rx_chk
    localparam logic [14:0] VEC [8] = '{
        15'b00_0_1_1_0_1_0_1_0_11111,   // R1
        15'b00_1_0_0_1_0_1_0_1_11111,   // R1
        15'b01_0_1_1_0_0_0_1_1_00111,   // R2 R3
        15'b01_1_0_0_1_1_1_0_0_00111,   // R2 R3
        15'b10_1_0_1_0_1_0_0_0_11111,   // R4
        15'b10_0_1_0_1_1_1_1_1_11111,   // R4
        15'b11_0_1_1_0_0_0_1_1_00000,   // R5
        15'b11_1_0_0_1_1_1_0_0_00000    // R5
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [8:0] outs();
        return {txd_pin, rx_serial_in, rx_clk_en, tx_clk_en, tx_stat_en,
                tx_cpu_en, rx_cpu_en, rx_err_en, rx_chk_en};
    endfunction

    // One sample strobe with the given RxD value, then back to the negedge.
    task automatic sample(input logic v, input logic is_stop);
        rxd_pin = v; rx_samp_stb = 1'b1; rx_stop_stb = is_stop;
        @(negedge clk);
        rx_samp_stb = 1'b0; rx_stop_stb = 1'b0;
    endtask

    task automatic rx_tick();
        rx_baud_tick = 1'b1;
        @(negedge clk);
        rx_baud_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 2'b01; tx_enable = 1'b0; stop_len = 2'd2;
        rxd_pin = 1'b0; tx_serial = 1'b0; rx_samp_stb = 1'b0; rx_stop_stb = 1'b0;
        rx_baud_tick = 1'b0; tx_baud_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: echo register idle high after reset, RxD low but not sampled
        chk("R10 reset echo high", {8'b0, txd_pin}, 9'b1);
        @(negedge clk);

        // Table walk: steady routing per mode
        for (int i = 0; i < 8; i++) begin
            mode_sel     = VEC[i][14:13];
            tx_serial    = VEC[i][11];
            rx_baud_tick = VEC[i][10];
            tx_baud_tick = VEC[i][9];
            sample(VEC[i][12], 1'b0);
            #1;
            chk($sformatf("R1-5 vector %0d (R1 R2 R3 R4 R5)", i), outs(), VEC[i][8:0]);
            @(negedge clk);
        end
        rx_baud_tick = 1'b0; tx_baud_tick = 1'b0;

        // R4: RxD toggles and strobes have no effect in local loopback
        mode_sel = 2'b10; tx_serial = 1'b0;
        sample(1'b0, 1'b0);
        rxd_pin = 1'b1; #1;
        chk("R4 rxd ignored", {7'b0, txd_pin, rx_serial_in}, 9'b10);

        // R6: break passes through in remote loopback
        @(negedge clk);
        mode_sel = 2'b11;
        sample(1'b0, 1'b0);
        sample(1'b0, 1'b0);
        sample(1'b0, 1'b0); #1;
        chk("R6 break held", {8'b0, txd_pin}, 9'b0);
        @(negedge clk);
        rxd_pin = 1'b1; @(negedge clk); #1;
        chk("R6 break until strobe", {8'b0, txd_pin}, 9'b0);
        sample(1'b1, 1'b0); #1;
        chk("R6 break released", {8'b0, txd_pin}, 9'b1);

        // R7: mid-character switch from echo to normal is immediate
        @(negedge clk);
        mode_sel = 2'b01; tx_enable = 1'b1; tx_serial = 1'b1;
        sample(1'b0, 1'b0); #1;
        chk("R7 echo before switch", {8'b0, txd_pin}, 9'b0);
        @(negedge clk);
        mode_sel = 2'b00; #1;
        chk("R7 immediate switch", {8'b0, txd_pin}, 9'b1);

        // R8: stop-bit hold on leaving echo with transmitter enabled
        @(negedge clk);
        mode_sel = 2'b01; tx_serial = 1'b0; stop_len = 2'd2;
        sample(1'b1, 1'b1);
        mode_sel = 2'b00; #1;
        chk("R8 hold in switch cycle", {8'b0, txd_pin}, 9'b1);
        rx_tick(); #1;
        chk("R8 hold after first tick", {7'b0, txd_pin, tx_stat_en}, 9'b10);
        rx_tick(); #1;
        chk("R8 released after last tick", {7'b0, txd_pin, tx_stat_en}, 9'b01);

        // R8: stop_len 0 holds for exactly one tick
        @(negedge clk);
        mode_sel = 2'b11; stop_len = 2'd0;
        sample(1'b1, 1'b1);
        mode_sel = 2'b10; #1;
        chk("R8 len0 hold", {8'b0, txd_pin}, 9'b1);
        @(negedge clk); #1;
        chk("R8 len0 still held", {7'b0, tx_cpu_en, rx_serial_in}, 9'b0);
        rx_tick(); #1;
        chk("R8 len0 released", {8'b0, tx_cpu_en}, 9'b1);

        // R9: same departure with transmitter disabled switches at once
        @(negedge clk);
        mode_sel = 2'b01; stop_len = 2'd2; tx_enable = 1'b0; tx_serial = 1'b0;
        sample(1'b1, 1'b1);
        mode_sel = 2'b00; #1;
        chk("R9 no hold when disabled", {8'b0, txd_pin}, 9'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule